// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Multi-Function Aggregation

This block arbitrates interrupts for a small 8-bit processor core. It has five primary sources: an external pin, timer/event counter 0, timer/event counter 1, a time base and a multi-function group. Each primary source keeps a request flag and an enable bit. One master enable gates all of them. Three secondary events (a comparator and two op-amp events) each keep their own flag and enable. Any enabled secondary event raises the single multi-function primary flag. The secondary flags stay set until software clears them, so a service routine can poll them to find which event fired.

When a primary source is pending and the controller is idle, the controller accepts the highest-priority one. A short latency counter then models the time the core needs to finish its current instruction. After that delay the controller pulses a vector-request strobe that carries a one-hot vector index. On that strobe it clears the master enable and the flag of the serviced source. A return pulse from the core sets the master enable again, and any request that arrived in the meantime is then taken. Software reaches the flags and enables through a small register port. Writes take effect on the clock edge, and reads are combinational.

The vector strobe is a plain pulse with no back-pressure. The core has to take the vector in the cycle the strobe is high. The register port has no handshake either: a write completes in the cycle it is presented.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset every register reads zero and vec_req is low. The register map is:
  - address 0: primary flags in bits 4:0.
  - address 1: primary enables in bits 4:0, with the master enable in bit 7.
  - address 2: secondary flags in bits 2:0.
  - address 3: secondary enables in bits 2:0.
- R2: A primary source is accepted only when its flag, its enable and the master enable are all 1. A flag that is set but not enabled stays latched and produces no strobe.
- R3: Of several pending sources, the lowest bit position wins: external 0, timer 0 1, timer 1 2, time base 3, multi-function 4. vec_idx is one-hot at that bit position while vec_req is high.
- R4: vec_req goes high 2 cycles after the cycle in which a request is accepted, or 3 cycles after it if core_long is high in the acceptance cycle. A request is accepted in the cycle after its flag is set.
- R5: At the strobe, the master enable and the serviced source's flag are cleared. The other flags are unchanged.
- R6: A core_reti pulse sets the master enable. Requests still latched are then accepted in priority order.
- R7: A secondary event always sets its own flag. It sets the multi-function primary flag only when its secondary enable is 1.
- R8: Servicing never clears secondary flags. Only a software write to address 2 clears them.
- R9: A software write of 1 to a primary flag raises the interrupt exactly as a hardware event would.
- R10: When a hardware event and a software write hit the same flag in the same cycle, the flag ends up 1.
- R11: With parameter HAS_T1 = 0, the timer 1 flag and enable (bit 2) read 0 whatever is written or signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_evt | input | 1 | External interrupt event pulse |
| tmr0_evt | input | 1 | Timer/event counter 0 overflow pulse |
| tmr1_evt | input | 1 | Timer/event counter 1 overflow pulse |
| tbase_evt | input | 1 | Time base tick pulse |
| sec_evt | input | 3 | Secondary event pulses: comparator, op-amp 0, op-amp 1 |
| core_long | input | 1 | Core is executing a two-cycle instruction |
| core_reti | input | 1 | Core executed a return from interrupt |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| vec_req | output | 1 | Vector-request strobe to the core |
| vec_idx | output | 5 | One-hot vector index, valid with vec_req |

## Verification
The assertions assume the following about the inputs:
- core_reti arrives only while no vector request is under way.
- Event inputs are single-cycle pulses.
- Software does not write the enable register in the same cycle as a strobe.

The stimulus keeps to these assumptions. Every return pulse and register write is issued several idle cycles after the scoreboard has seen the previous strobe. Every event is driven high for exactly one cycle.

// File: rtl/irq_pkg.sv
`timescale 1ns/1ps
package irq_pkg;
  localparam int NPRI     = 5;
  localparam int NSEC     = 3;
  localparam int DW       = 8;
  localparam int AW       = 2;
  localparam int MIE_BIT  = 7;
  localparam int T1_POS   = 2;

  typedef enum logic [AW-1:0] {
    RA_PFLAG = 2'd0,
    RA_PEN   = 2'd1,
    RA_SFLAG = 2'd2,
    RA_SEN   = 2'd3
  } reg_addr_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/irq_sec_group.sv
`timescale 1ns/1ps
module irq_sec_group #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         wr_flag,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flags,
  output logic [N-1:0] ens,
  output logic         mf_set
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[g] <= 1'b0;
        ens[g]   <= 1'b0;
      end else begin
        if (wr_flag) flags[g] <= wdata[g];
        if (evt[g])  flags[g] <= 1'b1;   // event beats software
        if (wr_en)   ens[g]   <= wdata[g];
      end
    end
  end

  assign mf_set = |(evt & ens);

  // R8: without a software write, no secondary flag ever drops
  p_sec_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_flag |=> ((flags & $past(flags)) == $past(flags)));

  // R7: each event leaves its own flag set
  p_sec_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((flags & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_prim_bank.sv
`timescale 1ns/1ps
module irq_prim_bank #(
  parameter int N      = 5,
  parameter bit HAS_T1 = 1'b1,
  parameter int T1_BIT = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hw_set,
  input  logic         wr_flag,
  input  logic         wr_en,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic [N-1:0] ens
);
  localparam logic [N-1:0] T1_MASK = N'(1) << T1_BIT;
  localparam logic [N-1:0] KEEP    = HAS_T1 ? {N{1'b1}} : ~T1_MASK;

  for (genvar g = 0; g < N; g++) begin : g_src
    if (KEEP[g]) begin : g_impl
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          flags[g] <= 1'b0;
          ens[g]   <= 1'b0;
        end else begin
          if (wr_flag)   flags[g] <= wdata[g];
          if (clr[g])    flags[g] <= 1'b0;
          if (hw_set[g]) flags[g] <= 1'b1;  // hardware set wins
          if (wr_en)     ens[g]   <= wdata[g];
        end
      end
    end else begin : g_absent
      assign flags[g] = 1'b0;
      assign ens[g]   = 1'b0;
    end
  end

  // R10: a hardware set always leaves the flag high
  p_hw_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((hw_set & KEEP) != '0) |=> ((flags & $past(hw_set & KEEP)) == $past(hw_set & KEEP)));

  // R5: the serviced flag is cleared unless re-raised in that cycle
  p_entry_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~hw_set) != '0) |=> ((flags & $past(clr & ~hw_set)) == '0));
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] win,
  output logic         any
);
  for (genvar g = 0; g < N; g++) begin : g_pri
    if (g == 0) begin : g_top
      assign win[g] = req[g];
    end else begin : g_low
      assign win[g] = req[g] & ~(|req[g-1:0]);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq #(
  parameter int N         = 5,
  parameter int LAT_SHORT = 2,
  parameter int LAT_LONG  = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pend_any,
  input  logic [N-1:0] pend_win,
  input  logic         long_instr,
  output logic         accept,
  output logic         vec_req,
  output logic [N-1:0] vec_idx
);
  import irq_pkg::*;

  localparam int CW = $clog2(LAT_LONG + 1);
  localparam logic [CW-1:0] TGT_S = CW'(LAT_SHORT);
  localparam logic [CW-1:0] TGT_L = CW'(LAT_LONG);

  seq_state_e     state;
  logic [CW-1:0]  cnt;
  logic [N-1:0]   win_q;
  logic           long_q;
  logic [CW-1:0]  target;

  assign target  = long_q ? TGT_L : TGT_S;
  assign accept  = (state == SQ_IDLE) && pend_any;
  assign vec_req = (state == SQ_WAIT) && (cnt == target);
  assign vec_idx = vec_req ? win_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
      win_q  <= '0;
      long_q <= 1'b0;
    end else if (accept) begin
      state  <= SQ_WAIT;
      cnt    <= CW'(1);
      win_q  <= pend_win;
      long_q <= long_instr;
    end else if (vec_req) begin
      state  <= SQ_IDLE;
      cnt    <= '0;
    end else if (state == SQ_WAIT) begin
      cnt    <= cnt + CW'(1);
    end
  end

  // R4: never a strobe right after acceptance
  p_no_early_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !vec_req);

  // R4: a strobe is only produced from a request that was waiting
  p_strobe_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> $past(state == SQ_WAIT));

  // R3: the latched winner is a single source
  p_win_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ($countones(pend_win) == 1));
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
module irq_prio_ctrl #(
  parameter bit HAS_T1    = 1'b1,
  parameter int LAT_SHORT = 2,
  parameter int LAT_LONG  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_evt,
  input  logic       tmr0_evt,
  input  logic       tmr1_evt,
  input  logic       tbase_evt,
  input  logic [2:0] sec_evt,
  input  logic       core_long,
  input  logic       core_reti,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       vec_req,
  output logic [4:0] vec_idx
);
  import irq_pkg::*;

  logic [NPRI-1:0] pflag, pen, hw_set, pend, win;
  logic [NSEC-1:0] sflag, sen;
  logic            mf_set, pend_any, accept, mie;
  logic            wr_pf, wr_pe, wr_sf, wr_se;
  logic            wdata_unused;

  assign wr_pf = reg_wr && (reg_addr == RA_PFLAG);
  assign wr_pe = reg_wr && (reg_addr == RA_PEN);
  assign wr_sf = reg_wr && (reg_addr == RA_SFLAG);
  assign wr_se = reg_wr && (reg_addr == RA_SEN);
  assign wdata_unused = ^reg_wdata[MIE_BIT-1:NPRI];

  irq_sec_group #(.N(NSEC)) u_sec (
    .clk(clk), .rst_n(rst_n), .evt(sec_evt),
    .wr_flag(wr_sf), .wr_en(wr_se), .wdata(reg_wdata[NSEC-1:0]),
    .flags(sflag), .ens(sen), .mf_set(mf_set)
  );

  assign hw_set = {mf_set, tbase_evt, tmr1_evt, tmr0_evt, ext_evt};

  irq_prim_bank #(.N(NPRI), .HAS_T1(HAS_T1), .T1_BIT(T1_POS)) u_prim (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set),
    .wr_flag(wr_pf), .wr_en(wr_pe), .wdata(reg_wdata[NPRI-1:0]),
    .clr(vec_idx), .flags(pflag), .ens(pen)
  );

  assign pend = pflag & pen & {NPRI{mie}};

  irq_pick #(.N(NPRI)) u_pick (.req(pend), .win(win), .any(pend_any));

  irq_entry_seq #(.N(NPRI), .LAT_SHORT(LAT_SHORT), .LAT_LONG(LAT_LONG)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_any(pend_any), .pend_win(win),
    .long_instr(core_long), .accept(accept), .vec_req(vec_req), .vec_idx(vec_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mie <= 1'b0;
    end else begin
      if (wr_pe)     mie <= reg_wdata[MIE_BIT];
      if (vec_req)   mie <= 1'b0;
      if (core_reti) mie <= 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      RA_PFLAG: reg_rdata[NPRI-1:0] = pflag;
      RA_PEN: begin
        reg_rdata[NPRI-1:0] = pen;
        reg_rdata[MIE_BIT]  = mie;
      end
      RA_SFLAG: reg_rdata[NSEC-1:0] = sflag;
      RA_SEN:   reg_rdata[NSEC-1:0] = sen;
      default:  reg_rdata = '0;
    endcase
  end

  // R3: a strobe names exactly one source
  p_vec_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> ($countones(vec_idx) == 1));

  // R2: acceptance needs the master enable and an enabled flag
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (mie && ((pflag & pen) != '0)));

  // R5: entry drops the master enable
  p_entry_mie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !core_reti) |=> !mie);

  // R6: return re-arms the master enable
  p_reti_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    core_reti |=> mie);
endmodule

// File: tb/irq_prio_ctrl_tb.sv
`timescale 1ns/1ps
module irq_prio_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_evt = 0, tmr0_evt = 0, tmr1_evt = 0, tbase_evt = 0;
  logic [2:0] sec_evt = '0;
  logic       core_long = 0, core_reti = 0;
  logic       reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, rdata_n1;
  logic       vec_req, vreq_n1;
  logic [4:0] vec_idx, vidx_n1;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  bit done = 0;

  typedef struct { logic [4:0] idx; int at; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  irq_prio_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .tmr0_evt(tmr0_evt),
    .tmr1_evt(tmr1_evt), .tbase_evt(tbase_evt), .sec_evt(sec_evt),
    .core_long(core_long), .core_reti(core_reti), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .vec_req(vec_req), .vec_idx(vec_idx)
  );

  irq_prio_ctrl #(.HAS_T1(1'b0)) u_dut_n1 (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .tmr0_evt(tmr0_evt),
    .tmr1_evt(tmr1_evt), .tbase_evt(tbase_evt), .sec_evt(sec_evt),
    .core_long(core_long), .core_reti(core_reti), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_n1),
    .vec_req(vreq_n1), .vec_idx(vidx_n1)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && vec_req) begin
      if (q.size() == 0) begin
        chk(1'b0, "R2 unexpected strobe", int'(vec_idx), 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(vec_idx == e.idx, "R3 vector index", int'(vec_idx), int'(e.idx));
        chk(cyc == e.at, "R4 strobe cycle", cyc, e.at);
      end
    end
  end

  // all tasks start and end at a falling edge
  task automatic push(input logic [4:0] idx, input int at);
    exp_t e;
    e.idx = idx;
    e.at  = at;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; last_cyc = cyc;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pulse(input logic [3:0] p, input logic [2:0] s, input bit reti, input bit lng);
    {tbase_evt, tmr1_evt, tmr0_evt, ext_evt} = p;
    sec_evt = s; core_reti = reti; core_long = lng; last_cyc = cyc;
    @(negedge clk);
    {tbase_evt, tmr1_evt, tmr0_evt, ext_evt} = '0;
    sec_evt = '0; core_reti = 0; core_long = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    chk(reg_rdata == exp, req, int'(reg_rdata), int'(exp));
  endtask

  task automatic rd_n1(input logic [1:0] a, input logic [7:0] exp);
    reg_addr = a;
    #1;
    chk(rdata_n1 == exp, "R11 timer1 absent", int'(rdata_n1), int'(exp));
  endtask

  task automatic reti_then(input logic [4:0] idx);
    pulse(4'b0000, 3'b000, 1'b1, 1'b0);
    push(idx, last_cyc + 3);
    idle(4);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, 8'h00, "R1 primary flags");
    rd(2'd1, 8'h00, "R1 enables");
    rd(2'd2, 8'h00, "R1 secondary flags");
    rd(2'd3, 8'h00, "R1 secondary enables");
    chk(vec_req == 1'b0, "R1 vec_req low", int'(vec_req), 0);

    // basic hardware event, entry clearing and return
    wr(2'd1, 8'h9F);
    wr(2'd3, 8'h07);
    pulse(4'b0001, 3'b000, 1'b0, 1'b0);
    push(5'b00001, last_cyc + 3);
    idle(4);
    rd(2'd1, 8'h1F, "R5 master enable cleared");
    rd(2'd0, 8'h00, "R5 flag cleared");
    pulse(4'b0000, 3'b000, 1'b1, 1'b0);
    rd(2'd1, 8'h9F, "R6 master enable re-armed");

    // R9 software-set flags, R3 priority, R6 queued service
    wr(2'd1, 8'h1F);
    wr(2'd0, 8'h1E);
    wr(2'd1, 8'h9F);
    push(5'b00010, last_cyc + 3);
    idle(4);
    rd(2'd0, 8'h1C, "R5 only serviced flag cleared");
    reti_then(5'b00100);
    reti_then(5'b01000);
    reti_then(5'b10000);
    pulse(4'b0000, 3'b000, 1'b1, 1'b0);
    idle(3);
    rd(2'd0, 8'h00, "R9 all flags serviced");

    // R2 enable gating
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h01);
    idle(5);
    rd(2'd0, 8'h01, "R2 flag latched while disabled");
    wr(2'd1, 8'h81);
    push(5'b00001, last_cyc + 3);
    idle(4);
    pulse(4'b0000, 3'b000, 1'b1, 1'b0);
    wr(2'd1, 8'h9F);

    // R4 long instruction in the acceptance cycle
    pulse(4'b0010, 3'b000, 1'b0, 1'b0);
    push(5'b00010, last_cyc + 4);
    pulse(4'b0000, 3'b000, 1'b0, 1'b1);
    idle(4);
    pulse(4'b0000, 3'b000, 1'b1, 1'b0);
    idle(2);

    // R7 and R8 secondary sources
    wr(2'd3, 8'h01);
    pulse(4'b0000, 3'b010, 1'b0, 1'b0);
    idle(4);
    rd(2'd2, 8'h02, "R7 disabled secondary flag set");
    rd(2'd0, 8'h00, "R7 disabled secondary no group flag");
    pulse(4'b0000, 3'b001, 1'b0, 1'b0);
    push(5'b10000, last_cyc + 3);
    idle(4);
    rd(2'd2, 8'h03, "R8 secondary flags kept after service");
    rd(2'd0, 8'h00, "R5 group flag cleared");
    wr(2'd2, 8'h00);
    rd(2'd2, 8'h00, "R8 software clears secondary flags");
    pulse(4'b0000, 3'b000, 1'b1, 1'b0);
    idle(2);

    // R10 hardware set beats software write
    wr(2'd1, 8'h1F);
    reg_wr = 1; reg_addr = 2'd0; reg_wdata = 8'h00; ext_evt = 1;
    sec_evt = 3'b000;
    @(negedge clk);
    reg_wr = 0; ext_evt = 0;
    rd(2'd0, 8'h01, "R10 primary hw set wins");
    reg_wr = 1; reg_addr = 2'd2; reg_wdata = 8'h00; sec_evt = 3'b100;
    @(negedge clk);
    reg_wr = 0; sec_evt = 3'b000;
    rd(2'd2, 8'h04, "R10 secondary hw set wins");
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);

    // R11 variant without timer 1
    wr(2'd0, 8'h04);
    pulse(4'b0100, 3'b000, 1'b0, 1'b0);
    rd(2'd0, 8'h04, "R11 full variant keeps timer1 flag");
    rd_n1(2'd0, 8'h00);
    rd_n1(2'd1, 8'h1B);
    wr(2'd0, 8'h00);

    idle(6);
    chk(q.size() == 0, "R4 all expected strobes seen", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule